// File: doc/BRIEF.md
# Fly-by DMA Channel Controller

This block is one channel of a fly-by DMA engine. It moves words from an I/O peripheral straight into system memory without holding any data of its own. The peripheral drives the word onto the shared data bus while the controller supplies the memory address and fires the memory-write and I/O-read strobes together. The controller only sequences the address, the strobes and the acknowledge. It never touches the data.

Software programs a start address, a word count and a mode (single-cycle or burst) while the channel is idle. When the peripheral raises its request, the channel asks the host CPU for the bus with a hold request and waits for the hold acknowledge. Only then does it drive the bus. Each word takes one strobe clock followed by one recovery clock.

- In single-cycle mode the bus is handed back after every word.
- In burst mode words follow back to back until the count runs out or the request drops.

A terminal-count flag reports when the programmed count has been used up.

Top module: `flyby_dma`

## Requirements
- R1: While reset is high, and in the first cycle after it, `hrq`, `dack`, `bus_oe`, `mem_wr`, `io_rd` and `tc` are 0 and `mem_addr` is 0.
- R2: In idle, with a non-zero remaining count and `dreq` sampled high, `hrq` rises on the next clock. With a zero remaining count, `hrq` stays low whatever `dreq` does.
- R3: While `hrq` is high and `hlda` has not yet been sampled high, `bus_oe`, `mem_wr`, `io_rd` and `dack` stay 0 and `mem_addr` reads 0. The first strobe cycle starts on the clock after `hlda` is sampled high. Whenever `bus_oe` is 0, `mem_addr` is 0.
- R4: Every word raises `mem_wr` and `io_rd` together for exactly one clock. One recovery clock with both strobes low follows it.
- R5: `dack` is 1 during the strobe clock and the recovery clock of every word.
- R6: In single-cycle mode (`cfg_burst`=0), `hrq` falls on the clock after each word's recovery clock. If `dreq` is still high after `hlda` has been sampled low, a fresh `hrq` handshake starts.
- R7: In burst mode (`cfg_burst`=1), a new strobe follows the recovery clock directly if `dreq` was high during that recovery clock and words remain. Otherwise `hrq` falls.
- R8: After `hrq` falls, `dack` stays 1 until `dreq` is sampled low and falls on the next clock. `bus_oe` stays 1, showing the next address, until `hlda` is sampled low.
- R9: `mem_addr` during a word's strobe is the programmed start address plus the number of words already moved. The address is 16 bits wide and wraps modulo 2^16.
- R10: `tc` goes to 1 when the last programmed word completes. It stays 1 until the next accepted load, and no request is made while the count is zero.
- R11: A `cfg_load` pulse is accepted only when the channel is idle (`hrq` and `bus_oe` both low). A pulse at any other time changes neither the addresses used nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load pulse for the programming registers |
| cfg_addr | input | 16 | Start memory address to load |
| cfg_count | input | 16 | Number of words to move |
| cfg_burst | input | 1 | Mode to load: 1 = burst, 0 = single-cycle |
| dreq | input | 1 | Peripheral transfer request |
| hlda | input | 1 | Bus grant from the CPU |
| hrq | output | 1 | Bus request to the CPU |
| dack | output | 1 | Acknowledge to the peripheral |
| bus_oe | output | 1 | Controller owns address and strobe lines |
| mem_addr | output | 16 | Memory address (0 when not driven) |
| mem_wr | output | 1 | Memory-write strobe, active high |
| io_rd | output | 1 | I/O-read strobe, active high |
| tc | output | 1 | Terminal count reached |

## Verification
Single-cycle mode is run with the request held high for the whole run. A design that forgot to hand the bus back would run the words in one grant and show too few hold requests. A design that waited for the request to drop would hang.

In burst mode the request is withdrawn in the middle of a burst. This catches a design that samples the request at the wrong clock and moves an extra word. The same run resumes later and must carry on at the correct address with the remaining count.

A load pulse is issued in the middle of a transfer; a design that took it would jump to the new address or miss the terminal count. After the count is exhausted, the request is held high and must raise no bus request. The peripheral also drops its request as soon as it sees the acknowledge, which tests that the acknowledge falls exactly one clock after the request goes away.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ASK     = 3'd1,
        PH_STROBE  = 3'd2,
        PH_GAP     = 3'd3,
        PH_RELEASE = 3'd4
    } phase_e;

    typedef struct packed {
        logic hold_req;
        logic drive;
        logic strobe;
        logic ack;
    } bus_ctl_t;

    function automatic bus_ctl_t decode_phase(phase_e ph, logic ack_hold);
        bus_ctl_t c;
        c.hold_req = (ph == PH_ASK) || (ph == PH_STROBE) || (ph == PH_GAP);
        c.drive    = (ph == PH_STROBE) || (ph == PH_GAP) || (ph == PH_RELEASE);
        c.strobe   = (ph == PH_STROBE);
        c.ack      = (ph == PH_STROBE) || (ph == PH_GAP) ||
                     ((ph == PH_RELEASE) && ack_hold);
        return c;
    endfunction

endpackage

// File: rtl/flyby_dma_prog.sv
module flyby_dma_prog #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_count,
    input  logic          ld_burst,
    input  logic          word_done,
    output logic [AW-1:0] cur_addr,
    output logic          burst,
    output logic          has_work,
    output logic          last_word,
    output logic          tc
);
    localparam logic [AW-1:0] ADDR_STEP = AW'(1);
    localparam logic [CW-1:0] CNT_STEP  = CW'(1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            remain   <= '0;
            burst    <= 1'b0;
            tc       <= 1'b0;
        end else if (load_en) begin
            cur_addr <= ld_addr;
            remain   <= ld_count;
            burst    <= ld_burst;
            tc       <= 1'b0;
        end else if (word_done) begin
            cur_addr <= cur_addr + ADDR_STEP;
            remain   <= remain - CNT_STEP;
            if (last_word) begin
                tc <= 1'b1;
            end
        end
    end

    assign has_work  = (remain != '0);
    assign last_word = (remain == CNT_STEP);

endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
    import flyby_dma_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   dreq,
    input  logic   hlda,
    input  logic   has_work,
    input  logic   last_word,
    input  logic   burst,
    output phase_e phase,
    output logic   ack_hold,
    output logic   word_done,
    output logic   idle
);
    phase_e nxt;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:    if (dreq && has_work) nxt = PH_ASK;
            PH_ASK:     if (hlda) nxt = PH_STROBE;
            PH_STROBE:  nxt = PH_GAP;
            PH_GAP: begin
                if (!last_word && burst && dreq) nxt = PH_STROBE;
                else                             nxt = PH_RELEASE;
            end
            PH_RELEASE: if (!hlda) nxt = PH_IDLE;
            default:    nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            ack_hold <= 1'b0;
        end else begin
            phase <= nxt;
            unique case (phase)
                PH_GAP:     ack_hold <= (nxt == PH_RELEASE);
                PH_RELEASE: ack_hold <= ack_hold && dreq && (nxt == PH_RELEASE);
                default:    ack_hold <= 1'b0;
            endcase
        end
    end

    assign word_done = (phase == PH_GAP);
    assign idle      = (phase == PH_IDLE);

endmodule

// File: rtl/flyby_dma_drive.sv
module flyby_dma_drive
    import flyby_dma_pkg::*;
#(
    parameter int AW = 16
) (
    input  phase_e        phase,
    input  logic          ack_hold,
    input  logic [AW-1:0] cur_addr,
    output logic          hrq,
    output logic          dack,
    output logic          bus_oe,
    output logic          mem_wr,
    output logic          io_rd,
    output logic [AW-1:0] mem_addr
);
    bus_ctl_t ctl;

    assign ctl    = decode_phase(phase, ack_hold);
    assign hrq    = ctl.hold_req;
    assign bus_oe = ctl.drive;
    assign mem_wr = ctl.strobe;
    assign io_rd  = ctl.strobe;
    assign dack   = ctl.ack;

    for (genvar i = 0; i < AW; i++) begin : g_addr_gate
        assign mem_addr[i] = cur_addr[i] & ctl.drive;
    end

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
    import flyby_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_burst,
    input  logic          dreq,
    input  logic          hlda,
    output logic          hrq,
    output logic          dack,
    output logic          bus_oe,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wr,
    output logic          io_rd,
    output logic          tc
);
    phase_e        phase;
    logic          ack_hold;
    logic          word_done;
    logic          idle;
    logic          has_work;
    logic          last_word;
    logic          mode_burst;
    logic [AW-1:0] cur_addr;
    logic          load_en;

    assign load_en = cfg_load && idle;

    flyby_dma_prog #(.AW(AW), .CW(CW)) u_prog (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .ld_addr   (cfg_addr),
        .ld_count  (cfg_count),
        .ld_burst  (cfg_burst),
        .word_done (word_done),
        .cur_addr  (cur_addr),
        .burst     (mode_burst),
        .has_work  (has_work),
        .last_word (last_word),
        .tc        (tc)
    );

    flyby_dma_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .dreq      (dreq),
        .hlda      (hlda),
        .has_work  (has_work),
        .last_word (last_word),
        .burst     (mode_burst),
        .phase     (phase),
        .ack_hold  (ack_hold),
        .word_done (word_done),
        .idle      (idle)
    );

    flyby_dma_drive #(.AW(AW)) u_drive (
        .phase    (phase),
        .ack_hold (ack_hold),
        .cur_addr (cur_addr),
        .hrq      (hrq),
        .dack     (dack),
        .bus_oe   (bus_oe),
        .mem_wr   (mem_wr),
        .io_rd    (io_rd),
        .mem_addr (mem_addr)
    );

endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          dreq,
    input logic          hlda,
    input logic          cfg_load,
    input logic          hrq,
    input logic          dack,
    input logic          bus_oe,
    input logic [AW-1:0] mem_addr,
    input logic          mem_wr,
    input logic          io_rd,
    input logic          tc,
    input logic          burst
);
    a_r2_request_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(hrq) |-> ($past(dreq) && !$past(tc)));

    a_r3_strobe_under_grant: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (hrq && bus_oe && hlda));

    a_r3_drive_after_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(hlda));

    a_r3_quiet_undriven: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (mem_addr == '0 && !mem_wr && !io_rd && !dack));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (!mem_wr && !io_rd && dack));

    a_r5_ack_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (mem_wr || io_rd) |-> dack);

    a_r6_single_gives_up: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !burst) |=> ##1 !hrq);

    a_r8_ack_drop: assert property (@(posedge clk) disable iff (rst)
        (dack && !hrq && !dreq) |=> !dack);

    a_r9_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && $past(mem_wr, 2)) |-> (mem_addr == $past(mem_addr, 2) + AW'(1)));

    a_r10_tc_quiet: assert property (@(posedge clk) disable iff (rst)
        (tc && !hrq && !cfg_load) |=> !hrq);

endmodule

bind flyby_dma flyby_dma_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dreq     (dreq),
    .hlda     (hlda),
    .cfg_load (cfg_load),
    .hrq      (hrq),
    .dack     (dack),
    .bus_oe   (bus_oe),
    .mem_addr (mem_addr),
    .mem_wr   (mem_wr),
    .io_rd    (io_rd),
    .tc       (tc),
    .burst    (mode_burst)
);

// File: tb/flyby_dma_test.sv
module flyby_dma_test;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          cfg_burst = 1'b0;
    logic          dreq = 1'b0;
    logic          hlda = 1'b0;
    logic          hrq, dack, bus_oe, mem_wr, io_rd, tc;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int hrq_rises = 0;
    logic hrq_prev = 1'b0;
    logic [1:0] grant_pipe = 2'b00;
    int seen_addr[$];
    logic done = 1'b0;

    // reference model state
    int m_ph = 0;
    int m_addr = 0, m_rem = 0;
    bit m_burst = 0, m_tc = 0, m_hold = 0;

    always #4 clk = ~clk;

    flyby_dma uut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_burst(cfg_burst), .dreq(dreq), .hlda(hlda),
        .hrq(hrq), .dack(dack), .bus_oe(bus_oe), .mem_addr(mem_addr),
        .mem_wr(mem_wr), .io_rd(io_rd), .tc(tc)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        int nph;
        bit ld;
        if (rst) begin
            m_ph = 0; m_addr = 0; m_rem = 0; m_burst = 0; m_tc = 0; m_hold = 0;
        end else begin
            ld  = cfg_load && (m_ph == 0);
            nph = m_ph;
            if (m_ph == 0) begin
                if (dreq && m_rem != 0) nph = 1;
            end else if (m_ph == 1) begin
                if (hlda) nph = 2;
            end else if (m_ph == 2) begin
                nph = 3;
            end else if (m_ph == 3) begin
                m_addr = (m_addr + 1) % 65536;
                m_rem  = m_rem - 1;
                if (m_rem == 0) begin
                    m_tc = 1; nph = 4; m_hold = 1;
                end else if (m_burst && dreq) begin
                    nph = 2;
                end else begin
                    nph = 4; m_hold = 1;
                end
            end else begin
                m_hold = m_hold && dreq;
                if (!hlda) begin
                    nph = 0; m_hold = 0;
                end
            end
            m_ph = nph;
            if (ld) begin
                m_addr = int'(cfg_addr); m_rem = int'(cfg_count);
                m_burst = cfg_burst; m_tc = 0;
            end
        end
    end

    // CPU grant model, per-cycle comparison and monitors on the falling edge
    always @(negedge clk) begin
        int ex_oe;
        cycles++;
        if (!done) begin
            ex_oe = (m_ph >= 2) ? 1 : 0;
            check("R2 hrq", int'(hrq), (m_ph >= 1 && m_ph <= 3) ? 1 : 0);
            check("R3 bus_oe", int'(bus_oe), ex_oe);
            check("R3 R9 mem_addr", int'(mem_addr), ex_oe ? m_addr : 0);
            check("R4 mem_wr", int'(mem_wr), (m_ph == 2) ? 1 : 0);
            check("R4 io_rd", int'(io_rd), (m_ph == 2) ? 1 : 0);
            check("R5 R8 dack", int'(dack),
                  (m_ph == 2 || m_ph == 3 || (m_ph == 4 && m_hold)) ? 1 : 0);
            check("R10 tc", int'(tc), int'(m_tc));
        end
        if (hrq && !hrq_prev) hrq_rises++;
        hrq_prev = hrq;
        if (mem_wr) seen_addr.push_back(int'(mem_addr));
        grant_pipe = {grant_pipe[0], hrq};
        hlda = grant_pipe[1];
    end

    task automatic load(input int a, input int n, input bit b);
        @(negedge clk);
        cfg_load = 1'b1; cfg_addr = AW'(a); cfg_count = CW'(n); cfg_burst = b;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic expect_addrs(input string req, input int base, input int n);
        check({req, " word count"}, seen_addr.size(), n);
        for (int i = 0; i < n && i < seen_addr.size(); i++)
            check({req, " word address"}, seen_addr[i], (base + i) % 65536);
        seen_addr.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 hrq in reset", int'(hrq), 0);
        check("R1 tc in reset", int'(tc), 0);
        check("R1 addr in reset", int'(mem_addr), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset", int'({hrq, dack, bus_oe, mem_wr, io_rd, tc}), 0);

        // R2/R10: zero count, request ignored
        dreq = 1'b1;
        repeat (10) @(negedge clk);
        check("R2 R10 no request with zero count", hrq_rises, 0);
        dreq = 1'b0;

        // R6: single-cycle, request held high throughout
        load(16'h1000, 3, 1'b0);
        hrq_rises = 0;
        dreq = 1'b1;
        repeat (40) @(negedge clk);
        dreq = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 one handshake per word", hrq_rises, 3);
        expect_addrs("R6 R9", 16'h1000, 3);
        check("R10 tc after single run", int'(tc), 1);

        // R7: burst with request held high, one grant
        load(16'h2000, 4, 1'b1);
        hrq_rises = 0;
        dreq = 1'b1;
        repeat (30) @(negedge clk);
        dreq = 1'b0;
        repeat (6) @(negedge clk);
        check("R7 burst single grant", hrq_rises, 1);
        expect_addrs("R7 R9", 16'h2000, 4);

        // R7: burst interrupted by request drop, then resumed
        load(16'hFFFE, 5, 1'b1);
        hrq_rises = 0;
        dreq = 1'b1;
        while (seen_addr.size() < 2) @(negedge clk);
        dreq = 1'b0;
        repeat (15) @(negedge clk);
        check("R7 burst stops after drop", seen_addr.size(), 2);
        check("R10 tc not yet set", int'(tc), 0);
        dreq = 1'b1;
        repeat (30) @(negedge clk);
        dreq = 1'b0;
        repeat (6) @(negedge clk);
        check("R7 resumed burst grants", hrq_rises, 2);
        expect_addrs("R7 R9 wrap", 16'hFFFE, 5);
        check("R10 tc after resumed burst", int'(tc), 1);

        // R10: exhausted count keeps channel quiet
        hrq_rises = 0;
        dreq = 1'b1;
        repeat (12) @(negedge clk);
        dreq = 1'b0;
        check("R10 no request once exhausted", hrq_rises, 0);

        // R11: load while busy is ignored
        load(16'h4000, 2, 1'b0);
        dreq = 1'b1;
        while (!bus_oe) @(negedge clk);
        cfg_load = 1'b1; cfg_addr = 16'h5000; cfg_count = 7; cfg_burst = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        repeat (30) @(negedge clk);
        dreq = 1'b0;
        repeat (6) @(negedge clk);
        expect_addrs("R11 load ignored", 16'h4000, 2);
        check("R11 tc from original count", int'(tc), 1);

        // R8: peripheral withdraws request on acknowledge
        load(16'h6000, 2, 1'b0);
        for (int w = 0; w < 2; w++) begin
            dreq = 1'b1;
            while (!dack) @(negedge clk);
            dreq = 1'b0;
            while (dack) @(negedge clk);
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        expect_addrs("R8 handshake words", 16'h6000, 2);
        check("R8 dack low at end", int'(dack), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule